// File: doc/BRIEF.md
# Processor Thermal Throttle Controller

This block decides when a processor's clock-throttling circuit must be engaged. Two threshold flags come from an on-die digital sensor: one for the hot point and one for the catastrophic trip point. A third input is an asynchronous active-low request from the platform that forces throttling, for example to relieve a hot voltage regulator. A monitor-enable configuration bit gates all throttling. Two further bits choose whether an interrupt is raised when the hot indication asserts, when it clears, or both.

The hot indicator follows the sensor flag alone. The platform request throttles the part without ever driving that indicator. The catastrophic trip output latches, ignores the monitor-enable bit and can be cleared only by reset. It also raises a shutdown request, which stops all further throttling and interrupt activity. A sticky status flag records any platform request that was held for fewer than a parameterized number of clock cycles. That count stands in for a minimum recommended pulse width.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: `hot_n_o` goes low one clock edge after `hot_flag_i` is sampled high, and returns high one edge after it is sampled low.
- R2: `throttle_o` goes high two edges after `hot_flag_i` rises when `mon_en_i` is 1. It is never high at an edge where `mon_en_i` was 0.
- R3: With `mon_en_i` at 1, a low level on `force_req_n_i` raises `throttle_o` on the third edge, after a two-flop synchronizer and one register. `throttle_o` stays high until the request is released, and falls on the third edge after the release unless the hot flag holds it.
- R4: `force_req_n_i` never affects `hot_n_o`.
- R5: `irq_o` is a one-cycle high pulse on the edge after `hot_n_o` falls when `irq_rise_en_i` is 1. It is also a one-cycle pulse on the edge after `hot_n_o` rises when `irq_fall_en_i` is 1. With the matching enable at 0, no pulse is produced.
- R6: `trip_n_o` goes low and `shutdown_o` goes high one edge after `trip_flag_i` is sampled high, whatever the value of `mon_en_i`. Both then hold until reset.
- R7: From the edge where `shutdown_o` rises, `throttle_o` and `irq_o` stay low, while `hot_n_o` still follows the hot flag.
- R8: When a synchronized force request lasts fewer than `MIN_PULSE_CYC` cycles, `short_force_o` sets about three edges after release and holds until reset. A request of at least `MIN_PULSE_CYC` cycles leaves it clear.
- R9: During and right after reset, `hot_n_o` and `trip_n_o` are high, and `throttle_o`, `irq_o`, `shutdown_o` and `short_force_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_flag_i | input | 1 | Sensor flag: die at hot threshold (synchronous) |
| trip_flag_i | input | 1 | Sensor flag: die at catastrophic threshold (synchronous) |
| force_req_n_i | input | 1 | Platform throttle request, active low, asynchronous |
| mon_en_i | input | 1 | Enables throttling |
| irq_rise_en_i | input | 1 | Interrupt on hot assertion |
| irq_fall_en_i | input | 1 | Interrupt on hot de-assertion |
| hot_n_o | output | 1 | Hot indicator, active low |
| throttle_o | output | 1 | Throttle-circuit enable |
| irq_o | output | 1 | One-cycle interrupt pulse |
| trip_n_o | output | 1 | Sticky catastrophic trip, active low |
| shutdown_o | output | 1 | Shutdown request |
| short_force_o | output | 1 | Sticky flag: force request shorter than minimum |

## Verification
Results arrive at fixed edges after a stimulus. The hot and trip outputs follow one edge after the sensor flag. Throttle follows two edges after the hot flag and three edges after the force input. The interrupt arrives two edges after the hot flag, and the short-pulse flag about three edges after a release. The bench drives every input on a falling clock edge and then waits exactly that number of rising edges before it samples, also checking the edge before, so each check lands on the edge where the result is due. Level sweeps wait four edges so that every path has settled.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

    typedef struct packed {
        logic hot;       // registered hot flag (active high internally)
        logic trip;      // sticky catastrophic trip
        logic throttle;  // throttle enable
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{hot: 1'b0, trip: 1'b0, throttle: 1'b0};

endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tt_pulse_mon.sv
module tt_pulse_mon #(
    parameter int unsigned MIN_CYC = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic short_o
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          flag_d, flag_q;

    always_comb begin
        cnt_d  = cnt_q;
        flag_d = flag_q;
        if (level_i) begin
            if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
        end else if (cnt_q != '0) begin
            // request just ended: judge its length
            if (cnt_q < LIMIT) flag_d = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign short_o = flag_q;

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q);
endmodule

// File: rtl/tt_edge_pulse.sv
module tt_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    input  logic block_i,
    output logic pulse_o
);
    logic prev_d, prev_q;
    logic pulse_d, pulse_q;

    always_comb begin
        prev_d  = level_i;
        pulse_d = ~block_i &
                  (( level_i & ~prev_q & rise_en_i) |
                   (~level_i &  prev_q & fall_en_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= prev_d;
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;

    a_r5_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (prev_q != $past(prev_q)));
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned MIN_PULSE_CYC = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_flag_i,
    input  logic trip_flag_i,
    input  logic force_req_n_i,
    input  logic mon_en_i,
    input  logic irq_rise_en_i,
    input  logic irq_fall_en_i,
    output logic hot_n_o,
    output logic throttle_o,
    output logic irq_o,
    output logic trip_n_o,
    output logic shutdown_o,
    output logic short_force_o
);
    import thermal_pkg::*;

    ctl_state_t st_d, st_q;
    logic       force_n_s;
    logic       force_act;

    tt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (force_req_n_i),
        .q_o   (force_n_s)
    );

    assign force_act = ~force_n_s;

    tt_pulse_mon #(.MIN_CYC(MIN_PULSE_CYC)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (force_act),
        .short_o (short_force_o)
    );

    always_comb begin
        st_d          = st_q;
        st_d.hot      = hot_flag_i;
        st_d.trip     = st_q.trip | trip_flag_i;
        st_d.throttle = mon_en_i & ~st_d.trip & (st_q.hot | force_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_RESET;
        else        st_q <= st_d;
    end

    tt_edge_pulse u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (st_q.hot),
        .rise_en_i (irq_rise_en_i),
        .fall_en_i (irq_fall_en_i),
        .block_i   (st_d.trip),
        .pulse_o   (irq_o)
    );

    assign hot_n_o    = ~st_q.hot;
    assign throttle_o = st_q.throttle;
    assign trip_n_o   = ~st_q.trip;
    assign shutdown_o = st_q.trip;

    a_r6_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_n_o |=> !trip_n_o);
    a_r2_throttle_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        throttle_o |-> $past(mon_en_i));
    a_r7_no_throttle_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> !throttle_o);
    a_r7_no_irq_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> !irq_o);
    a_r6_shutdown_tracks_trip: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o == !trip_n_o);
endmodule

// File: tb/tb_thermal_throttle_ctrl.sv
module tb_thermal_throttle_ctrl;
    localparam int unsigned MINP = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic hot_flag_i, trip_flag_i, force_req_n_i, mon_en_i;
    logic irq_rise_en_i, irq_fall_en_i;
    logic hot_n_o, throttle_o, irq_o, trip_n_o, shutdown_o, short_force_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    thermal_throttle_ctrl #(.SYNC_STAGES(2), .MIN_PULSE_CYC(MINP)) dut (
        .clk(clk), .rst_n(rst_n), .hot_flag_i(hot_flag_i), .trip_flag_i(trip_flag_i),
        .force_req_n_i(force_req_n_i), .mon_en_i(mon_en_i),
        .irq_rise_en_i(irq_rise_en_i), .irq_fall_en_i(irq_fall_en_i),
        .hot_n_o(hot_n_o), .throttle_o(throttle_o), .irq_o(irq_o),
        .trip_n_o(trip_n_o), .shutdown_o(shutdown_o), .short_force_o(short_force_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hot_flag_i = 0; trip_flag_i = 0; force_req_n_i = 1; mon_en_i = 0;
        irq_rise_en_i = 0; irq_fall_en_i = 0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        do_reset();
        // R9 reset state
        check("R9 hot_n", hot_n_o, 1'b1);
        check("R9 trip_n", trip_n_o, 1'b1);
        check("R9 throttle", throttle_o, 1'b0);
        check("R9 irq", irq_o, 1'b0);
        check("R9 shutdown", shutdown_o, 1'b0);
        check("R9 short", short_force_o, 1'b0);

        // R1/R2/R3/R4 level sweep
        for (int i = 0; i < 8; i++) begin
            mon_en_i = i[2]; hot_flag_i = i[1]; force_req_n_i = ~i[0];
            step(4);
            check("R1 R4 hot_n level", hot_n_o, ~i[1]);
            check("R2 R3 throttle level", throttle_o, i[2] & (i[1] | i[0]));
        end
        hot_flag_i = 0; force_req_n_i = 1; mon_en_i = 1;
        step(4);

        // R1/R2 latency from hot flag
        hot_flag_i = 1;
        step(1);
        check("R1 hot_n after 1 edge", hot_n_o, 1'b0);
        check("R2 throttle not yet", throttle_o, 1'b0);
        step(1);
        check("R2 throttle after 2 edges", throttle_o, 1'b1);
        hot_flag_i = 0;
        step(1);
        check("R1 hot_n release", hot_n_o, 1'b1);
        step(3);

        // R3/R4 latency from force request
        force_req_n_i = 0;
        step(2);
        check("R3 throttle not yet", throttle_o, 1'b0);
        step(1);
        check("R3 throttle after 3 edges", throttle_o, 1'b1);
        check("R4 hot_n unaffected", hot_n_o, 1'b1);
        step(5);
        check("R3 throttle holds", throttle_o, 1'b1);
        force_req_n_i = 1;
        step(2);
        check("R3 throttle held to release", throttle_o, 1'b1);
        step(1);
        check("R3 throttle drops", throttle_o, 1'b0);

        // R5 interrupt edge selection sweep
        do_reset();
        for (int k = 0; k < 4; k++) begin
            irq_rise_en_i = k[0]; irq_fall_en_i = k[1];
            hot_flag_i = 1;
            step(1);
            check("R5 no irq yet (rise)", irq_o, 1'b0);
            step(1);
            check("R5 rise pulse", irq_o, k[0]);
            step(1);
            check("R5 rise pulse one cycle", irq_o, 1'b0);
            hot_flag_i = 0;
            step(1);
            check("R5 no irq yet (fall)", irq_o, 1'b0);
            step(1);
            check("R5 fall pulse", irq_o, k[1]);
            step(1);
            check("R5 fall pulse one cycle", irq_o, 1'b0);
        end

        // R8 short request sweep
        for (int len = 1; len <= 12; len++) begin
            do_reset();
            force_req_n_i = 0;
            step(len);
            force_req_n_i = 1;
            step(4);
            check("R8 short flag", short_force_o, (len < MINP) ? 1'b1 : 1'b0);
            step(3);
            check("R8 short flag holds", short_force_o, (len < MINP) ? 1'b1 : 1'b0);
        end

        // R6/R7 catastrophic trip
        do_reset();
        trip_flag_i = 1;
        step(1);
        check("R6 trip_n low without mon_en", trip_n_o, 1'b0);
        check("R6 shutdown high", shutdown_o, 1'b1);
        trip_flag_i = 0;
        step(5);
        check("R6 trip_n sticky", trip_n_o, 1'b0);
        check("R6 shutdown sticky", shutdown_o, 1'b1);
        mon_en_i = 1; irq_rise_en_i = 1; irq_fall_en_i = 1; hot_flag_i = 1;
        for (int c = 0; c < 3; c++) begin
            step(1);
            check("R7 irq blocked", irq_o, 1'b0);
            check("R7 throttle blocked (hot)", throttle_o, 1'b0);
        end
        check("R7 hot_n still follows", hot_n_o, 1'b0);
        force_req_n_i = 0;
        step(4);
        check("R7 throttle blocked (force)", throttle_o, 1'b0);
        force_req_n_i = 1; hot_flag_i = 0;
        step(2);
        check("R7 irq blocked on fall", irq_o, 1'b0);
        do_reset();
        check("R9 trip cleared by reset", trip_n_o, 1'b1);
        check("R9 shutdown cleared by reset", shutdown_o, 1'b0);

        // trip asserted while throttling: drops at the trip edge
        mon_en_i = 1; hot_flag_i = 1;
        step(3);
        check("R2 throttle before trip", throttle_o, 1'b1);
        trip_flag_i = 1;
        step(1);
        check("R7 throttle drops with trip", throttle_o, 1'b0);
        check("R6 trip_n with throttle active", trip_n_o, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule